// File: doc/BRIEF.md
# Slave-Port Arbiter with Default Master

This block decides which of nine bus masters is connected to one slave port of a multi-master interconnect. Each master drives a request line and a burst-end flag that marks the final beat of its burst. The block answers with a registered one-hot grant, the index of the connected master and a flag that says whether any master is connected. Configuration inputs give every master a 2-bit priority for this slave, cap how long one burst may hold the slave, and choose what happens when the slave falls idle.

Three idle policies exist. In the first, the slave is released from all masters, so the next master pays one extra cycle before its first beat. In the second, the slave stays with whichever master used it last. In the third, the slave parks on a master picked by a configured index. A master that is already connected when it raises its request is served in that same cycle. Any other master is granted one clock after it asks.

Top module: `slv_port_arb`

## Requirements
- R1: Synchronous active-high reset clears the grant vector, the connected flag and the owner index to zero, and sets the round-robin pointer to master 0. With equal priorities, the first contest after reset is therefore won by master 1.
- R2: Among the pending requesters other than the current owner, the master with the highest priority value wins. Master m's priority sits at bits [2m+1:2m] of the priority bus.
- R3: Requesters with equal top priority are ordered round-robin, beginning with the master after the one granted last by arbitration.
- R4: A master that is not connected and requests gets its grant on the first clock edge after its request is seen. The grant vector is always zero or one-hot.
- R5: With idle mode 0 (none), if the owner is not requesting or has just signalled its final beat, and no other master requests, the slave is disconnected at the next edge.
- R6: With idle mode 1 (last), the slave stays with the previous owner when nobody else requests. That master's grant is already high in the cycle it requests again.
- R7: With idle mode 2 (fixed), the idle slave is connected to the master named by the fixed-index input. That master's grant is already high in the cycle it requests.
- R8: Idle mode 3, and mode 2 with a fixed index above 8, behave as mode 0.
- R9: While the owner keeps requesting and has not flagged its final beat, its grant is held against any other request, unless the slot limit forces arbitration.
- R10: With a nonzero slot limit L, once the owner has held the slave for L active cycles and another master is requesting, arbitration runs on that cycle and the grant moves at the next edge. A limit of 0 never forces a move.
- R11: The owner index equals the bit position of the set grant bit, and the connected flag is high exactly when the grant vector is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 9 | Request per master |
| last_i | input | 9 | Final-beat flag per master |
| idle_mode_i | input | 2 | Idle policy: 0 none, 1 last, 2 fixed, 3 reserved |
| fixed_idx_i | input | 4 | Master parked on in fixed mode |
| prio_i | input | 18 | Two priority bits per master |
| slot_lim_i | input | 8 | Maximum active hold cycles, 0 for no limit |
| grant_o | output | 9 | One-hot grant, registered |
| owner_o | output | 4 | Index of the connected master |
| owned_o | output | 1 | A master is connected |

## Verification
The embedded properties watch, on every cycle, that the grant stays one-hot and agrees with the owner index, that an active burst is not broken except by a forced slot expiry, that a forced expiry always moves the grant, and that each idle policy lands on its target master when there are no requests. The winner among competing priorities, the round-robin rotation across successive contests, the exact cycle on which a slot limit fires, and the absence of a wait for a parked master can only be shown by the bench. It compares every cycle against a cycle model of the requirements, under directed sequences and under long randomized traffic with changing configuration.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;
  localparam int unsigned NUM_MST = 9;
  localparam int unsigned PRIO_W  = 2;
  localparam int unsigned SLOT_W  = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_MST);

  typedef enum logic [1:0] {
    IDLE_NONE  = 2'd0,
    IDLE_LAST  = 2'd1,
    IDLE_FIXED = 2'd2,
    IDLE_RSVD  = 2'd3
  } idle_mode_e;
endpackage

// File: rtl/slv_arb_pick.sv
// Priority pick with round-robin ordering among equal priorities.
module slv_arb_pick #(
  parameter int unsigned N  = 9,
  parameter int unsigned PW = 2,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [IW-1:0]   ptr_i,
  output logic            found_o,
  output logic [IW-1:0]   win_o
);
  logic [PW-1:0] best;

  always_comb begin
    found_o = 1'b0;
    win_o   = '0;
    best    = '0;
    // Scan starts one past the pointer; strict compare keeps the earliest tie.
    for (int off = 1; off <= int'(N); off++) begin
      int idx;
      idx = (int'(ptr_i) + off) % int'(N);
      if (cand_i[idx] && (!found_o || (prio_i[idx*PW +: PW] > best))) begin
        found_o = 1'b1;
        best    = prio_i[idx*PW +: PW];
        win_o   = idx[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/slv_arb_slot.sv
// Counts active hold cycles of the current owner and flags expiry.
module slv_arb_slot #(
  parameter int unsigned SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active_i,
  input  logic          restart_i,
  input  logic          contend_i,
  input  logic [SW-1:0] limit_i,
  output logic          expire_o
);
  localparam logic [SW-1:0] CNT_MAX = '1;

  logic [SW-1:0] cnt_q;

  assign expire_o = active_i && contend_i && (limit_i != '0) &&
                    (cnt_q >= (limit_i - 1'b1));

  always_ff @(posedge clk) begin
    if (rst)                              cnt_q <= '0;
    else if (restart_i)                   cnt_q <= '0;
    else if (active_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // R10: counter only runs past zero while an owner is active
  a_r10_cnt_idle: assert property (@(posedge clk) disable iff (rst)
    (!active_i) |=> (cnt_q == '0));
endmodule

// File: rtl/slv_arb_idle.sv
// Chooses where the slave parks when no arbitration winner exists.
module slv_arb_idle #(
  parameter int unsigned N  = 9,
  parameter int unsigned IW = 4
) (
  input  logic [1:0]    mode_i,
  input  logic [IW-1:0] fixed_i,
  input  logic          cur_v_i,
  input  logic [IW-1:0] cur_i,
  output logic          park_v_o,
  output logic [IW-1:0] park_o
);
  import slv_arb_pkg::*;

  always_comb begin
    park_v_o = 1'b0;
    park_o   = '0;
    unique case (idle_mode_e'(mode_i))
      IDLE_LAST: begin
        park_v_o = cur_v_i;
        park_o   = cur_i;
      end
      IDLE_FIXED: begin
        if (int'(fixed_i) < int'(N)) begin
          park_v_o = 1'b1;
          park_o   = fixed_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slv_port_arb.sv
module slv_port_arb #(
  parameter int unsigned N  = slv_arb_pkg::NUM_MST,
  parameter int unsigned PW = slv_arb_pkg::PRIO_W,
  parameter int unsigned SW = slv_arb_pkg::SLOT_W,
  parameter int unsigned IW = slv_arb_pkg::IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  last_i,
  input  logic [1:0]    idle_mode_i,
  input  logic [IW-1:0] fixed_idx_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [SW-1:0] slot_lim_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] owner_o,
  output logic          owned_o
);
  import slv_arb_pkg::*;

  logic [N-1:0]  grant_q, grant_d;
  logic [IW-1:0] own_q, own_d, rr_q, rr_d;
  logic          own_v_q, own_v_d;

  logic          active, final_beat, expire, release_now;
  logic [N-1:0]  others;
  logic          found;
  logic [IW-1:0] win;
  logic          park_v;
  logic [IW-1:0] park;

  assign active      = own_v_q && req_i[own_q];
  assign final_beat  = active && last_i[own_q];
  assign others      = req_i & ~grant_q;
  assign release_now = !active || final_beat || expire;

  slv_arb_pick #(.N(N), .PW(PW), .IW(IW)) u_pick (
    .cand_i (others),
    .prio_i (prio_i),
    .ptr_i  (rr_q),
    .found_o(found),
    .win_o  (win)
  );

  slv_arb_slot #(.SW(SW)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .active_i (active),
    .restart_i(release_now),
    .contend_i(|others),
    .limit_i  (slot_lim_i),
    .expire_o (expire)
  );

  slv_arb_idle #(.N(N), .IW(IW)) u_idle (
    .mode_i  (idle_mode_i),
    .fixed_i (fixed_idx_i),
    .cur_v_i (own_v_q),
    .cur_i   (own_q),
    .park_v_o(park_v),
    .park_o  (park)
  );

  always_comb begin
    own_v_d = own_v_q;
    own_d   = own_q;
    rr_d    = rr_q;
    if (release_now) begin
      if (found) begin
        own_v_d = 1'b1;
        own_d   = win;
        rr_d    = win;
      end else begin
        own_v_d = park_v;
        own_d   = park;
      end
    end
    grant_d = '0;
    if (own_v_d) grant_d[own_d] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      own_q   <= '0;
      own_v_q <= 1'b0;
      rr_q    <= '0;
    end else begin
      grant_q <= grant_d;
      own_q   <= own_v_d ? own_d : '0;
      own_v_q <= own_v_d;
      rr_q    <= rr_d;
    end
  end

  assign grant_o = grant_q;
  assign owner_o = own_q;
  assign owned_o = own_v_q;

  // R1: reset empties the port
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (grant_q == '0 && !own_v_q && rr_q == '0));
  // R4: never two grants
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));
  // R11: flag and index agree with the grant vector
  a_r11_owner_match: assert property (@(posedge clk) disable iff (rst)
    own_v_q |-> grant_q[own_q]);
  a_r11_flag_match: assert property (@(posedge clk) disable iff (rst)
    (grant_q == '0) == !own_v_q);
  // R9: an unfinished burst keeps the slave
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (active && !last_i[own_q] && !expire) |=> $stable(grant_q));
  // R10: slot expiry hands the slave to someone else
  a_r10_forced_move: assert property (@(posedge clk) disable iff (rst)
    expire |=> (grant_q != $past(grant_q)) && (grant_q != '0));
  // R5: no default master and no requests leaves the slave free
  a_r5_disconnect: assert property (@(posedge clk) disable iff (rst)
    (idle_mode_i == 2'd0 && req_i == '0) |=> !own_v_q);
  // R8: reserved mode acts as no default
  a_r8_reserved: assert property (@(posedge clk) disable iff (rst)
    (idle_mode_i == 2'd3 && req_i == '0) |=> !own_v_q);
  // R7: fixed mode parks on the configured master
  a_r7_fixed_park: assert property (@(posedge clk) disable iff (rst)
    (idle_mode_i == 2'd2 && int'(fixed_idx_i) < int'(N) && req_i == '0)
      |=> (own_v_q && own_q == $past(fixed_idx_i)));
  // R6: last mode keeps the previous owner when nobody else asks
  a_r6_last_keep: assert property (@(posedge clk) disable iff (rst)
    (idle_mode_i == 2'd1 && own_v_q && others == '0)
      |=> (own_v_q && own_q == $past(own_q)));
endmodule

// File: tb/slv_port_arb_tb.sv
`timescale 1ns/1ps
module slv_port_arb_tb_top;
  localparam int N = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  req = '0;
  logic [8:0]  lst = '0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  fidx = 4'd0;
  logic [17:0] prio = '0;
  logic [7:0]  lim = 8'd0;
  logic [8:0]  grant_o;
  logic [3:0]  owner_o;
  logic        owned_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R1";

  // cycle model state
  bit m_v = 0;
  int m_own = 0;
  int m_cnt = 0;
  int m_rr = 0;

  always #2.5 clk = ~clk;

  slv_port_arb dut_i (
    .clk(clk), .rst(rst), .req_i(req), .last_i(lst), .idle_mode_i(mode),
    .fixed_idx_i(fidx), .prio_i(prio), .slot_lim_i(lim),
    .grant_o(grant_o), .owner_o(owner_o), .owned_o(owned_o)
  );

  function automatic int pick(logic [8:0] c, logic [17:0] p, int ptr);
    int w = -1;
    int best = 0;
    for (int off = 1; off <= N; off++) begin
      int i = (ptr + off) % N;
      if (c[i] && (w < 0 || int'(p[2*i +: 2]) > best)) begin
        w = i;
        best = int'(p[2*i +: 2]);
      end
    end
    return w;
  endfunction

  // model from the requirements, advanced on each edge
  always @(posedge clk) begin
    if (rst) begin
      m_v = 0; m_own = 0; m_cnt = 0; m_rr = 0;
    end else begin
      bit act, fin, frc, rel;
      logic [8:0] oth;
      int w;
      act = m_v && req[m_own];
      fin = act && lst[m_own];
      oth = req;
      if (m_v) oth[m_own] = 1'b0;
      frc = act && (lim != 0) && (m_cnt >= int'(lim) - 1) && (oth != 0);
      rel = !act || fin || frc;
      if (!rel) begin
        if (m_cnt < 255) m_cnt++;
      end else begin
        m_cnt = 0;
        w = pick(oth, prio, m_rr);
        if (w >= 0) begin
          m_v = 1; m_own = w; m_rr = w;
        end else if (mode == 2'd1) begin
          // keep as is
        end else if (mode == 2'd2 && fidx < 9) begin
          m_v = 1; m_own = int'(fidx);
        end else begin
          m_v = 0; m_own = 0;
        end
      end
    end
  end

  // compare outputs every cycle away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      logic [8:0] eg;
      eg = '0;
      if (m_v) eg[m_own] = 1'b1;
      checks++;
      if (grant_o !== eg || owned_o !== m_v || (m_v && owner_o !== 4'(m_own))) begin
        fails++;
        $display("FAIL %s: grant=%b owner=%0d owned=%b expected grant=%b owner=%0d owned=%b",
                 tag, grant_o, owner_o, owned_o, eg, m_own, m_v);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic expect_own(string t, bit v, int idx);
    checks++;
    if (owned_o !== v || (v && owner_o !== 4'(idx))) begin
      fails++;
      $display("FAIL %s: owned=%b owner=%0d expected owned=%b owner=%0d",
               t, owned_o, owner_o, v, idx);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    checks++;
    if (grant_o !== '0) begin
      fails++;
      $display("FAIL R1: grant=%b expected %b", grant_o, 9'b0);
    end
    expect_own("R1", 0, 0);

    // R1 and R3: all equal, pointer at 0 so master 1 wins
    tag = "R3"; req = '1; lst = '1;
    tick(1);
    expect_own("R1", 1, 1);
    tick(1);
    expect_own("R3", 1, 2);
    req = '0; lst = '0;
    tick(1);
    // R5: mode 0 releases
    tag = "R5";
    tick(1);
    expect_own("R5", 0, 0);

    // R2: highest priority wins
    tag = "R2";
    prio = '0; prio[2*6 +: 2] = 2'd3; prio[2*3 +: 2] = 2'd1;
    req = 9'b001001001; req[6] = 1'b1; lst = '1;
    tick(1);
    expect_own("R2", 1, 6);
    req = '0; prio = '0; tick(2);

    // R6: last mode keeps owner, zero wait on re-request
    tag = "R6"; mode = 2'd1;
    req[2] = 1'b1; lst[2] = 1'b1;
    tick(1);
    expect_own("R4", 1, 2);
    req = '0;
    tick(3);
    expect_own("R6", 1, 2);
    req[2] = 1'b1;
    checks++;
    if (grant_o[2] !== 1'b1) begin
      fails++;
      $display("FAIL R6: grant[2]=%b expected 1", grant_o[2]);
    end
    tick(1);
    req = '0; lst = '0;

    // R7: fixed parking, zero wait
    tag = "R7"; mode = 2'd2; fidx = 4'd5;
    tick(2);
    expect_own("R7", 1, 5);
    req[5] = 1'b1; lst[5] = 1'b1;
    checks++;
    if (grant_o[5] !== 1'b1) begin
      fails++;
      $display("FAIL R7: grant[5]=%b expected 1", grant_o[5]);
    end
    tick(1);
    req = '0; lst = '0;

    // R8: out of range index and reserved mode
    tag = "R8"; fidx = 4'd12;
    tick(2);
    expect_own("R8", 0, 0);
    mode = 2'd3; fidx = 4'd4;
    tick(2);
    expect_own("R8", 0, 0);

    // R9 and R10: master 0 holds a long burst, master 4 waits
    tag = "R10"; mode = 2'd0; lim = 8'd3;
    req[0] = 1'b1;
    tick(1);
    expect_own("R9", 1, 0);
    req[4] = 1'b1;
    tick(2);
    expect_own("R9", 1, 0);
    tick(1);
    expect_own("R10", 1, 4);
    req = '0; tick(2);
    lim = 8'd0; req[0] = 1'b1;
    tick(1);
    req[4] = 1'b1;
    tick(20);
    expect_own("R10", 1, 0);
    req = '0; tick(2);

    // random traffic with shifting configuration
    tag = "R4";
    for (int c = 0; c < 6000; c++) begin
      if (c % 64 == 0) begin
        mode = 2'($urandom_range(0, 3));
        fidx = 4'($urandom_range(0, 11));
        lim  = 8'($urandom_range(0, 5));
      end
      if (c % 128 == 0) prio = 18'($urandom);
      for (int m = 0; m < N; m++) begin
        if ($urandom_range(0, 7) == 0) req[m] = ~req[m];
        lst[m] = ($urandom_range(0, 3) == 0);
      end
      if (c % 500 > 450) req = '0;
      tick(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule